// File: doc/BRIEF.md
# Quad DAC Serial Control Interface

This block is the digital front end of a four-channel 10-bit digital-to-analog converter. A host writes it through a 4-wire serial port: a serial clock, a data line, an active-low chip select and a frame-sync strobe. Each 16-bit word selects one channel. It sets that channel's settling speed, its software power-down bit and its 10-bit code. All four serial pins and the two control pins are synchronised into the block's own system clock. A small state machine then finds the edges, assembles the frame and commits it.

A committed word goes into the addressed channel's input latch. A second latch per channel drives the converter. This output latch follows the input latch while the load-enable line is low and holds while it is high. The host can therefore preload all four channels and then change them together. A hardware power-down line forces every channel's power-down output active, whatever its own setting. Reset clears all codes, selects slow settling and clears every software power-down bit.

The receiver state machine has three states:
- RX_IDLE waits for a frame. The transition IDLE→SHIFT is taken on a falling frame-sync edge while chip select is low.
- RX_SHIFT samples one data bit on each falling serial-clock edge. SHIFT→ARMED is taken on the sixteenth falling edge. SHIFT→IDLE (abort) is taken when chip select goes high.
- RX_ARMED holds a complete word. ARMED→IDLE (commit) is taken on the next rising serial-clock edge, a rising frame-sync edge, or chip select being high. This transition issues the write.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset, every channel code is 0, every speed flag is 0 (slow) and every power-down output is 0 while the hardware power-down line is high.
- R2: A frame is 16 bits, most significant first. One bit is sampled on each falling serial-clock edge, starting after a falling frame-sync edge that arrives while chip select is low. Bits [15:14] are the channel address, bit 13 is the speed flag (1 = fast), bit 12 is the software power-down bit (1 = down) and bits [11:2] are the code.
- R3: A committed frame changes only the channel it addresses (00 = channel 0, 01 = channel 1, 10 = channel 2, 11 = channel 3). Code bits of channel n appear at dac_code[10n+9:10n].
- R4: A falling frame-sync edge while chip select is high starts no frame, and the clocked bits change no output.
- R5: A frame cut short by chip select going high before the sixteenth bit is discarded, and all latches keep their contents.
- R6: A complete frame is committed either on the rising serial-clock edge after the sixteenth bit or on a rising frame-sync edge, whichever comes first.
- R7: While ldac_n is high, the codes, speed flags and software power-down state at the outputs do not change. Once ldac_n is low, the outputs take the latest input-latch contents, which are the last frame written to each channel.
- R8: While pd_n is low, every pwr_dn bit is 1, and codes and speed flags still follow R7. Once pd_n returns high, each pwr_dn bit again equals its channel's software power-down bit.
- R9: Frame bits [1:0] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial and control pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| din | input | 1 | Serial data, most significant bit first |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync; its falling edge starts a frame |
| ldac_n | input | 1 | Output-latch enable; high holds, low lets outputs follow |
| pd_n | input | 1 | Active-low hardware power-down for all channels |
| dac_code | output | NCH*CODE_W | Packed output codes, channel n at bits [10n+9:10n] |
| fast_mode | output | NCH | Per-channel settling speed, 1 = fast |
| pwr_dn | output | NCH | Per-channel effective power-down, 1 = down |

## Verification
The bench builds the block with its default parameters: four channels, 10-bit codes, a 16-bit frame and two synchroniser stages. These values make the full address space reachable. Every channel can be written from the vector table, so each address decode and each bit position of the field layout is observed. Because the two synchroniser stages keep the pin-to-output latency short, the bench can drive serial half-periods of only four system clocks. That leaves room for aborted frames, both commit edges, held loads and hardware power-down within a brief run.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // receiver sequencer states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_ARMED = 2'd2
    } rx_state_t;

endpackage

// File: rtl/qdac_in_sync.sv
module qdac_in_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CODE_W  = 10,
    parameter int FRAME_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_q,
    input  logic                       din_q,
    input  logic                       cs_q,
    input  logic                       fs_q,
    output rx_state_t                  state,
    output logic                       wr_en,
    output logic [$clog2(NCH)-1:0]     wr_addr,
    output logic                       wr_fast,
    output logic                       wr_pd,
    output logic [CODE_W-1:0]          wr_code
);

    localparam int ADDR_W   = $clog2(NCH);
    localparam int ADDR_LSB = FRAME_W - ADDR_W;
    localparam int FAST_BIT = ADDR_LSB - 1;
    localparam int PD_BIT   = ADDR_LSB - 2;
    localparam int CODE_LSB = PD_BIT - CODE_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    rx_state_t          nxt;
    logic               sclk_d, fs_d, cs_d;
    logic               sclk_fall, sclk_rise, fs_fall, fs_rise;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_bit;

    // edge detection on already-synchronised levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            fs_d   <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_q;
            fs_d   <= fs_q;
            cs_d   <= cs_q;
        end
    end

    assign sclk_fall = sclk_d & ~sclk_q;
    assign sclk_rise = ~sclk_d & sclk_q;
    assign fs_fall   = fs_d & ~fs_q;
    assign fs_rise   = ~fs_d & fs_q;
    assign last_bit  = (bit_cnt == CNT_W'(FRAME_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and write strobe
    always_comb begin
        nxt   = state;
        wr_en = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (fs_fall && !cs_q) begin
                    nxt = RX_SHIFT;
                end
            end
            RX_SHIFT: begin
                if (cs_q) begin
                    nxt = RX_IDLE;
                end else if (sclk_fall && last_bit) begin
                    nxt = RX_ARMED;
                end
            end
            RX_ARMED: begin
                if (sclk_rise || fs_rise || cs_q) begin
                    wr_en = 1'b1;
                    nxt   = RX_IDLE;
                end
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == RX_IDLE) begin
            bit_cnt <= '0;
        end else if (state == RX_SHIFT && sclk_fall) begin
            shreg   <= {shreg[FRAME_W-2:0], din_q};
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    assign wr_addr = shreg[FRAME_W-1 -: ADDR_W];
    assign wr_fast = shreg[FAST_BIT];
    assign wr_pd   = shreg[PD_BIT];
    assign wr_code = shreg[CODE_LSB +: CODE_W];

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
    parameter int NCH    = 4,
    parameter int CODE_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NCH)-1:0]  wr_addr,
    input  logic                    wr_fast,
    input  logic                    wr_pd,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic                    ldac_q,
    input  logic                    pd_q,
    output logic [NCH-1:0]          wr_sel,
    output logic [NCH*CODE_W-1:0]   dac_code,
    output logic [NCH-1:0]          fast_mode,
    output logic [NCH-1:0]          pwr_dn
);

    localparam int ADDR_W = $clog2(NCH);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CODE_W-1:0] in_code, out_code;
        logic              in_fast, in_pd, out_fast, out_pd;

        assign wr_sel[ch] = wr_en && (wr_addr == ADDR_W'(ch));

        // input latch: written by a committed frame
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_code <= '0;
                in_fast <= 1'b0;
                in_pd   <= 1'b0;
            end else if (wr_sel[ch]) begin
                in_code <= wr_code;
                in_fast <= wr_fast;
                in_pd   <= wr_pd;
            end
        end

        // output latch: follows the input latch while load is enabled
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_code <= '0;
                out_fast <= 1'b0;
                out_pd   <= 1'b0;
            end else if (!ldac_q) begin
                out_code <= in_code;
                out_fast <= in_fast;
                out_pd   <= in_pd;
            end
        end

        // hardware power-down overrides the channel's own setting
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pwr_dn[ch] <= 1'b0;
            end else begin
                pwr_dn[ch] <= out_pd | ~pd_q;
            end
        end

        assign dac_code[ch*CODE_W +: CODE_W] = out_code;
        assign fast_mode[ch]                 = out_fast;
    end

endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int CODE_W      = 10,
    parameter int FRAME_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  din,
    input  logic                  cs_n,
    input  logic                  fs,
    input  logic                  ldac_n,
    input  logic                  pd_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        fast_mode,
    output logic [NCH-1:0]        pwr_dn
);

    localparam int          ADDR_W   = $clog2(NCH);
    localparam int          NPIN     = 6;
    // idle levels: pd_n, ldac_n, fs, cs_n high; din low; sclk high
    localparam logic [NPIN-1:0] PIN_IDLE = 6'b111101;

    logic [NPIN-1:0]   pin_raw, pin_q;
    logic              sclk_lvl, din_lvl, cs_lvl, fs_lvl, ldac_lvl, pd_lvl;
    rx_state_t         rx_state;
    logic              wr_en, wr_fast, wr_pd;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_code;
    logic [NCH-1:0]    wr_sel;

    assign pin_raw = {pd_n, ldac_n, fs, cs_n, din, sclk};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        qdac_in_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(PIN_IDLE[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_raw[g]),
            .q    (pin_q[g])
        );
    end

    assign sclk_lvl = pin_q[0];
    assign din_lvl  = pin_q[1];
    assign cs_lvl   = pin_q[2];
    assign fs_lvl   = pin_q[3];
    assign ldac_lvl = pin_q[4];
    assign pd_lvl   = pin_q[5];

    qdac_frame_rx #(
        .NCH    (NCH),
        .CODE_W (CODE_W),
        .FRAME_W(FRAME_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_q (sclk_lvl),
        .din_q  (din_lvl),
        .cs_q   (cs_lvl),
        .fs_q   (fs_lvl),
        .state  (rx_state),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_fast(wr_fast),
        .wr_pd  (wr_pd),
        .wr_code(wr_code)
    );

    qdac_chan_bank #(
        .NCH   (NCH),
        .CODE_W(CODE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_fast  (wr_fast),
        .wr_pd    (wr_pd),
        .wr_code  (wr_code),
        .ldac_q   (ldac_lvl),
        .pd_q     (pd_lvl),
        .wr_sel   (wr_sel),
        .dac_code (dac_code),
        .fast_mode(fast_mode),
        .pwr_dn   (pwr_dn)
    );

endmodule

// File: rtl/qdac_serial_ctrl_chk.sv
module qdac_serial_ctrl_chk
    import qdac_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input rx_state_t             rx_state,
    input logic                  cs_lvl,
    input logic                  ldac_lvl,
    input logic                  pd_lvl,
    input logic                  wr_en,
    input logic [NCH-1:0]        wr_sel,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic [NCH-1:0]        fast_mode,
    input logic [NCH-1:0]        pwr_dn
);

    // R3: a write reaches at most one channel
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R3: every write reaches exactly one channel
    p_write_hits_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_sel) == 1));

    // R4: chip select high keeps the receiver idle
    p_cs_keeps_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && cs_lvl) |=> (rx_state == RX_IDLE));

    // R5: chip select high during shifting aborts without a write
    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_SHIFT && cs_lvl) |=> (rx_state == RX_IDLE && !$past(wr_en)));

    // R6: a commit returns the receiver to idle
    p_commit_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rx_state == RX_IDLE));

    // R7: load disabled keeps the output latch frozen
    p_ldac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ldac_lvl) |-> ($stable(dac_code) && $stable(fast_mode)));

    // R8: hardware power-down forces every channel down
    p_pd_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pd_lvl) |-> (&pwr_dn));

endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(
    .NCH   (NCH),
    .CODE_W(CODE_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_state (rx_state),
    .cs_lvl   (cs_lvl),
    .ldac_lvl (ldac_lvl),
    .pd_lvl   (pd_lvl),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .dac_code (dac_code),
    .fast_mode(fast_mode),
    .pwr_dn   (pwr_dn)
);

// File: tb/qdac_serial_ctrl_tb_top.sv
module qdac_serial_ctrl_tb_top;

    localparam int NCH    = 4;
    localparam int CODE_W = 10;
    localparam int NVEC   = 8;

    // R2 field layout: {addr[15:14], fast[13], pd[12], code[11:2], ignored[1:0]}
    // R9: ignored bits vary across the table
    localparam logic [15:0] FRAMES [NVEC] = '{
        {2'd0, 1'b1, 1'b0, 10'h3FF, 2'b11},
        {2'd1, 1'b0, 1'b1, 10'h155, 2'b00},
        {2'd2, 1'b1, 1'b1, 10'h2AA, 2'b01},
        {2'd3, 1'b0, 1'b0, 10'h001, 2'b10},
        {2'd0, 1'b0, 1'b0, 10'h200, 2'b00},
        {2'd1, 1'b1, 1'b0, 10'h1FF, 2'b11},
        {2'd2, 1'b0, 1'b0, 10'h000, 2'b10},
        {2'd3, 1'b1, 1'b1, 10'h3FE, 2'b01}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, din = 1'b0, cs_n = 1'b1, fs = 1'b1;
    logic ldac_n = 1'b0, pd_n = 1'b1;
    logic [NCH*CODE_W-1:0] dac_code;
    logic [NCH-1:0]        fast_mode, pwr_dn;

    int n_chk = 0;
    int n_fail = 0;

    // reference model: input latch and output latch per channel
    logic [CODE_W-1:0] m_in_code  [NCH];
    logic              m_in_fast  [NCH];
    logic              m_in_pd    [NCH];
    logic [CODE_W-1:0] m_out_code [NCH];
    logic              m_out_fast [NCH];
    logic              m_out_pd   [NCH];

    always #2.5 clk = ~clk;

    qdac_serial_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .din      (din),
        .cs_n     (cs_n),
        .fs       (fs),
        .ldac_n   (ldac_n),
        .pd_n     (pd_n),
        .dac_code (dac_code),
        .fast_mode(fast_mode),
        .pwr_dn   (pwr_dn)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] w);
        int ch;
        ch = int'(w[15:14]);
        m_in_code[ch] = w[11:2];
        m_in_fast[ch] = w[13];
        m_in_pd[ch]   = w[12];
    endtask

    task automatic model_load();
        for (int i = 0; i < NCH; i++) begin
            m_out_code[i] = m_in_code[i];
            m_out_fast[i] = m_in_fast[i];
            m_out_pd[i]   = m_in_pd[i];
        end
    endtask

    task automatic check_all(input string req);
        logic [NCH*CODE_W-1:0] e_code;
        logic [NCH-1:0]        e_fast, e_pd;
        for (int i = 0; i < NCH; i++) begin
            e_code[i*CODE_W +: CODE_W] = m_out_code[i];
            e_fast[i] = m_out_fast[i];
            e_pd[i]   = m_out_pd[i] | ~pd_n;
        end
        check(dac_code == e_code, {req, " code"}, 64'(dac_code), 64'(e_code));
        check(fast_mode == e_fast, {req, " speed"}, 64'(fast_mode), 64'(e_fast));
        check(pwr_dn == e_pd, {req, " powerdown"}, 64'(pwr_dn), 64'(e_pd));
    endtask

    // drive one frame; nbits < 16 cuts it short, fs_commit ends it with fs rising
    task automatic send(input logic [15:0] w, input int nbits, input bit fs_commit,
                        input bit cs_active);
        cs_n = !cs_active;
        wait_clks(4);
        fs = 1'b0;
        wait_clks(4);
        for (int i = 0; i < nbits; i++) begin
            din = w[15-i];
            wait_clks(4);
            sclk = 1'b0;
            wait_clks(4);
            if (!(fs_commit && i == nbits - 1)) sclk = 1'b1;
            wait_clks(4);
        end
        fs = 1'b1;
        wait_clks(4);
        cs_n = 1'b1;
        sclk = 1'b1;
        wait_clks(20);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_in_code[i] = '0; m_in_fast[i] = 1'b0; m_in_pd[i] = 1'b0;
        end
        model_load();
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        check_all("R1 reset state");

        // vector table: R2 field decode, R3 addressing, R9 ignored bits
        for (int v = 0; v < NVEC; v++) begin
            send(FRAMES[v], 16, 1'b0, 1'b1);
            model_write(FRAMES[v]);
            model_load();
            check_all("R2 R3 R9 table frame");
        end

        // R9: only bits [1:0] differ, outputs must be identical
        send({2'd2, 1'b1, 1'b0, 10'h0F0, 2'b00}, 16, 1'b0, 1'b1);
        model_write({2'd2, 1'b1, 1'b0, 10'h0F0, 2'b00});
        model_load();
        send({2'd2, 1'b1, 1'b0, 10'h0F0, 2'b11}, 16, 1'b0, 1'b1);
        check_all("R9 ignored tail bits");

        // R4: chip select inactive, frame must be ignored
        send({2'd1, 1'b0, 1'b1, 10'h0AA, 2'b00}, 16, 1'b0, 1'b0);
        check_all("R4 cs inactive");

        // R5: frame aborted after 10 bits
        send({2'd0, 1'b1, 1'b1, 10'h123, 2'b00}, 10, 1'b0, 1'b1);
        check_all("R5 aborted frame");
        // R5: the next complete frame is still accepted
        send({2'd0, 1'b0, 1'b1, 10'h321, 2'b00}, 16, 1'b0, 1'b1);
        model_write({2'd0, 1'b0, 1'b1, 10'h321, 2'b00});
        model_load();
        check_all("R5 frame after abort");

        // R6: commit on frame-sync rising edge
        send({2'd3, 1'b1, 1'b0, 10'h2C3, 2'b00}, 16, 1'b1, 1'b1);
        model_write({2'd3, 1'b1, 1'b0, 10'h2C3, 2'b00});
        model_load();
        check_all("R6 fs commit");

        // R7: load disabled holds outputs; last write per channel wins
        ldac_n = 1'b1;
        wait_clks(6);
        send({2'd1, 1'b1, 1'b0, 10'h011, 2'b00}, 16, 1'b0, 1'b1);
        model_write({2'd1, 1'b1, 1'b0, 10'h011, 2'b00});
        send({2'd1, 1'b0, 1'b1, 10'h3C0, 2'b00}, 16, 1'b0, 1'b1);
        model_write({2'd1, 1'b0, 1'b1, 10'h3C0, 2'b00});
        send({2'd2, 1'b1, 1'b1, 10'h0CC, 2'b00}, 16, 1'b1, 1'b1);
        model_write({2'd2, 1'b1, 1'b1, 10'h0CC, 2'b00});
        check_all("R7 held outputs");
        ldac_n = 1'b0;
        wait_clks(10);
        model_load();
        check_all("R7 released load");

        // R8: hardware power-down forces all channels, codes still update
        pd_n = 1'b0;
        wait_clks(10);
        check_all("R8 hardware powerdown");
        send({2'd0, 1'b1, 1'b0, 10'h155, 2'b00}, 16, 1'b0, 1'b1);
        model_write({2'd0, 1'b1, 1'b0, 10'h155, 2'b00});
        model_load();
        check_all("R8 write during powerdown");
        pd_n = 1'b1;
        wait_clks(10);
        check_all("R8 powerdown released");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule